// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address of up to 40 bits by reading a two-level table of 32-bit entries from memory. The first level is a directory of 1024 entries found through a base register; each directory entry either points to a second-level table of 1024 entries that maps 4 KB pages, or, when large pages are enabled, maps a 4 MB page directly. A large-page directory entry supplies extra physical address bits from its middle field, so a 4 MB page may sit above the 4 GB line.

The walker owns one memory port with a valid/ready handshake. It reads entries, writes back the accessed flag of a directory entry that points to a table, and writes back the accessed and dirty flags of the leaf entry. It combines the user and writable flags of both levels, decides whether the access is allowed, and finishes with a one-cycle done pulse carrying either the physical address or a fault code. On a fault it also stores the faulting linear address. With paging turned off it returns the linear address unchanged and touches no memory. An address-bit-20 gate input can force bit 20 of every memory address and of the result to zero.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `done` is 0, `mem_valid` is 0 and `fault_addr` is 0.
- R2: With `ctl_paging` at 0 an accepted request finishes with no memory access, no fault, and `phys_addr` equal to the linear address, zero-extended.
- R3: The directory entry is read at {base[31:12], lin[31:22], 00}; the table entry at {dir_entry[31:12], lin[21:12], 00}; a 4 KB result is {table_entry[31:12], lin[11:0]}.
- R4: A memory request keeps `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` unchanged until `mem_ready` is seen; read data is taken in the handshake cycle; the access sequence is exactly the reads and write-backs these requirements call for.
- R5: An entry with bit 0 (present) clear at either level ends the walk with a fault whose code bit 0 is 0.
- R6: On the 4 KB path, a directory entry whose bit 5 (accessed) is clear is written back with bit 5 set before the table entry is read.
- R7: When the access is allowed, the leaf entry is written once with bit 5 set and, for a write, bit 6 (dirty) set; no write happens if neither bit changes, and none after a fault.
- R8: With `ctl_large` at 1 and directory bit 7 set, the result is {dir[20:13], dir[31:22], lin[21:0]} and the directory entry is the leaf; with `ctl_large` at 0, bit 7 is ignored and the 4 KB walk is made.
- R9: A large-page directory entry with bit 21 set faults with code bits 3 (reserved) and 0 set.
- R10: Fault code bit 1 is 1 for a write access (kind 1), bit 2 is 1 for a user access; `fault_addr` takes the linear address on each fault and holds it until the next fault.
- R11: With `ctl_a20_gate` at 0, bit 20 of every memory address and of the resulting physical address is 0.
- R12: Bit 2 (user) and bit 1 (writable) of both levels are ANDed; a user access needs the user flag; a write needs the writable flag, unless it is a supervisor write with `ctl_wprot` at 0; a fetch (kind 2) is checked as a read; a refusal faults with code bit 0 set.
- R13: A request is accepted only while `req_ready` is 1, which is only when idle; `done` is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request is taken |
| req_lin | input | 32 | Linear address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Access made at user privilege |
| ctl_paging | input | 1 | Paging enabled |
| ctl_large | input | 1 | 4 MB pages enabled |
| ctl_wprot | input | 1 | Supervisor writes honour the writable flag |
| ctl_a20_gate | input | 1 | 0 forces address bit 20 low |
| ctl_base | input | 32 | Directory base register |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | PA_W | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 32 | Read data, valid in the handshake cycle |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk ended in a page fault |
| phys_addr | output | PA_W | Translated address |
| fault_code | output | 4 | {reserved, user, write, protection} |
| fault_addr | output | 32 | Linear address of the last fault |

## Verification
A wrong stored entry or a wrong state step shows first on the memory port: the next request carries a wrong address, a missing or extra write-back, or wrong write data, and it is caught in the very handshake cycle where it happens, before the walk ends. Errors in permission merging or fault coding stay hidden until the done pulse, one cycle after the last entry is evaluated, where the result, code and fault address are compared. A wrong large-page or address-gate decision shows as a shifted table address on the following read.

// File: rtl/pw_pkg.sv
package pw_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RD_DIR,
      S_EV_DIR,
      S_WR_DIR,
      S_RD_TBL,
      S_EV_TBL,
      S_CHECK,
      S_WR_LEAF,
      S_RESP
   } walk_st_e;

   // entry flag positions
   localparam int B_PRES    = 0;
   localparam int B_RW      = 1;
   localparam int B_USR     = 2;
   localparam int B_ACC     = 5;
   localparam int B_DIRTY   = 6;
   localparam int B_PS      = 7;
   localparam int B_LG_RSVD = 21;
   localparam int LG_HI_LSB = 13;
   localparam int LG_HI_MAX = 8;
   localparam int ENT_W     = 32;

   typedef struct packed {
      logic rsvd;
      logic user;
      logic write;
      logic prot;
   } flt_code_t;

endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
   import pw_pkg::*;
#(
   parameter int PA_W     = 40,
   parameter bit LARGE_EN = 1'b1
) (
   input  logic [ENT_W-1:0] base,
   input  logic [31:0]      lin,
   input  logic [ENT_W-1:0] pde,
   input  logic [ENT_W-1:0] pte,
   input  logic             a20_gate,
   output logic [PA_W-1:0]  dir_addr,
   output logic [PA_W-1:0]  tbl_addr,
   output logic [PA_W-1:0]  phys_flat,
   output logic [PA_W-1:0]  phys_small,
   output logic [PA_W-1:0]  phys_large
);
   localparam int HI_W = PA_W - 32;

   logic [PA_W-1:0] a20m;
   logic            unused_bits;

   always_comb begin
      a20m     = '1;
      a20m[20] = a20_gate;
   end

   assign dir_addr   = PA_W'({base[31:12], lin[31:22], 2'b00}) & a20m;
   assign tbl_addr   = PA_W'({pde[31:12], lin[21:12], 2'b00}) & a20m;
   assign phys_flat  = PA_W'(lin) & a20m;
   assign phys_small = PA_W'({pte[31:12], lin[11:0]}) & a20m;

   generate
      if (!LARGE_EN) begin : g_no_large
         assign phys_large = '0;
      end else if (HI_W == 0) begin : g_large_32
         assign phys_large = PA_W'({pde[31:22], lin[21:0]}) & a20m;
      end else begin : g_large_hi
         assign phys_large = {pde[LG_HI_LSB +: HI_W], pde[31:22], lin[21:0]} & a20m;
      end
   endgenerate

   assign unused_bits = ^{base[11:0], pde[12:0], pte[11:0]};

endmodule

// File: rtl/pw_perm.sv
module pw_perm
   import pw_pkg::*;
(
   input  logic [ENT_W-1:0] pde,
   input  logic [ENT_W-1:0] pte,
   input  logic             leaf_is_dir,
   input  logic             user,
   input  logic             is_wr,
   input  logic             wprot,
   output logic             deny,
   output logic             need_upd,
   output logic [ENT_W-1:0] leaf_new
);
   logic [ENT_W-1:0] leaf;
   logic             eff_u;
   logic             eff_rw;

   always_comb begin
      leaf   = leaf_is_dir ? pde : pte;
      eff_u  = pde[B_USR] & (leaf_is_dir | pte[B_USR]);
      eff_rw = pde[B_RW]  & (leaf_is_dir | pte[B_RW]);
      deny   = (user & ~eff_u) | (is_wr & ~eff_rw & (user | wprot));

      leaf_new        = leaf;
      leaf_new[B_ACC] = 1'b1;
      if (is_wr) leaf_new[B_DIRTY] = 1'b1;
      need_upd = (leaf_new != leaf);
   end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pw_pkg::*;
#(
   parameter int PA_W     = 40,
   parameter bit LARGE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [31:0]      req_lin,
   input  logic [1:0]       req_kind,
   input  logic             req_user,
   input  logic             ctl_paging,
   input  logic             ctl_large,
   input  logic             ctl_wprot,
   input  logic             ctl_a20_gate,
   input  logic [31:0]      ctl_base,
   output logic             mem_valid,
   output logic             mem_write,
   output logic [PA_W-1:0]  mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic             mem_ready,
   input  logic [31:0]      mem_rdata,
   output logic             done,
   output logic             fault,
   output logic [PA_W-1:0]  phys_addr,
   output logic [3:0]       fault_code,
   output logic [31:0]      fault_addr
);

   generate
      if (PA_W < 32 || PA_W > 32 + LG_HI_MAX) begin : g_bad_pa_w
         initial $fatal(1, "pt_walker: PA_W must lie in 32..40");
      end
   endgenerate

   walk_st_e         st, st_nx;
   acc_kind_e        kind_q;
   logic [31:0]      lin_q, lin_sel;
   logic             user_q, lg_q, lg_hit, is_wr;
   logic [ENT_W-1:0] pde_q, pte_q, leaf_new, dir_wb;
   logic [PA_W-1:0]  dir_addr, tbl_addr, phys_flat, phys_small, phys_large, leaf_phys;
   logic             deny, need_upd;
   logic             fin, fin_flt;
   flt_code_t        fin_code;
   logic [PA_W-1:0]  fin_phys;

   assign is_wr     = (kind_q == ACC_WRITE);
   assign lin_sel   = (st == S_IDLE) ? req_lin : lin_q;
   assign req_ready = (st == S_IDLE);
   assign leaf_phys = lg_q ? phys_large : phys_small;

   always_comb begin
      dir_wb        = pde_q;
      dir_wb[B_ACC] = 1'b1;
   end

   generate
      if (LARGE_EN) begin : g_lg_on
         assign lg_hit = ctl_large & pde_q[B_PS];
      end else begin : g_lg_off
         logic unused_lg;
         assign unused_lg = ctl_large;
         assign lg_hit    = 1'b0;
      end
   endgenerate

   pw_addr_gen #(.PA_W(PA_W), .LARGE_EN(LARGE_EN)) u_addr (
      .base       (ctl_base),
      .lin        (lin_sel),
      .pde        (pde_q),
      .pte        (pte_q),
      .a20_gate   (ctl_a20_gate),
      .dir_addr   (dir_addr),
      .tbl_addr   (tbl_addr),
      .phys_flat  (phys_flat),
      .phys_small (phys_small),
      .phys_large (phys_large)
   );

   pw_perm u_perm (
      .pde         (pde_q),
      .pte         (pte_q),
      .leaf_is_dir (lg_q),
      .user        (user_q),
      .is_wr       (is_wr),
      .wprot       (ctl_wprot),
      .deny        (deny),
      .need_upd    (need_upd),
      .leaf_new    (leaf_new)
   );

   // memory port drive
   always_comb begin
      mem_valid = 1'b0;
      mem_write = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st)
         S_RD_DIR: begin
            mem_valid = 1'b1;
            mem_addr  = dir_addr;
         end
         S_WR_DIR: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_addr  = dir_addr;
            mem_wdata = dir_wb;
         end
         S_RD_TBL: begin
            mem_valid = 1'b1;
            mem_addr  = tbl_addr;
         end
         S_WR_LEAF: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_addr  = lg_q ? dir_addr : tbl_addr;
            mem_wdata = leaf_new;
         end
         default: ;
      endcase
   end

   // walk sequencing and completion decision
   always_comb begin
      st_nx    = st;
      fin      = 1'b0;
      fin_flt  = 1'b0;
      fin_code = '{rsvd: 1'b0, user: user_q, write: is_wr, prot: 1'b0};
      fin_phys = leaf_phys;
      unique case (st)
         S_IDLE: begin
            if (req_valid) begin
               if (!ctl_paging) begin
                  fin      = 1'b1;
                  fin_phys = phys_flat;
               end else begin
                  st_nx = S_RD_DIR;
               end
            end
         end
         S_RD_DIR: if (mem_ready) st_nx = S_EV_DIR;
         S_EV_DIR: begin
            if (!pde_q[B_PRES]) begin
               fin     = 1'b1;
               fin_flt = 1'b1;
            end else if (lg_hit) begin
               if (pde_q[B_LG_RSVD]) begin
                  fin           = 1'b1;
                  fin_flt       = 1'b1;
                  fin_code.rsvd = 1'b1;
                  fin_code.prot = 1'b1;
               end else begin
                  st_nx = S_CHECK;
               end
            end else if (!pde_q[B_ACC]) begin
               st_nx = S_WR_DIR;
            end else begin
               st_nx = S_RD_TBL;
            end
         end
         S_WR_DIR: if (mem_ready) st_nx = S_RD_TBL;
         S_RD_TBL: if (mem_ready) st_nx = S_EV_TBL;
         S_EV_TBL: begin
            if (!pte_q[B_PRES]) begin
               fin     = 1'b1;
               fin_flt = 1'b1;
            end else begin
               st_nx = S_CHECK;
            end
         end
         S_CHECK: begin
            if (deny) begin
               fin           = 1'b1;
               fin_flt       = 1'b1;
               fin_code.prot = 1'b1;
            end else if (need_upd) begin
               st_nx = S_WR_LEAF;
            end else begin
               fin = 1'b1;
            end
         end
         S_WR_LEAF: if (mem_ready) fin = 1'b1;
         S_RESP:    st_nx = S_IDLE;
         default:   st_nx = S_IDLE;
      endcase
      if (fin) st_nx = S_RESP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         kind_q     <= ACC_READ;
         lin_q      <= '0;
         user_q     <= 1'b0;
         lg_q       <= 1'b0;
         pde_q      <= '0;
         pte_q      <= '0;
         done       <= 1'b0;
         fault      <= 1'b0;
         phys_addr  <= '0;
         fault_code <= '0;
         fault_addr <= '0;
      end else begin
         st   <= st_nx;
         done <= fin;
         if (st == S_IDLE && req_valid) begin
            lin_q  <= req_lin;
            kind_q <= acc_kind_e'(req_kind);
            user_q <= req_user;
            lg_q   <= 1'b0;
         end
         if (st == S_RD_DIR && mem_ready) pde_q <= mem_rdata;
         if (st == S_RD_TBL && mem_ready) pte_q <= mem_rdata;
         if (st == S_EV_DIR) lg_q <= lg_hit;
         if (fin) begin
            fault <= fin_flt;
            if (fin_flt) begin
               fault_code <= fin_code;
               fault_addr <= lin_q;
            end else begin
               phys_addr <= fin_phys;
            end
         end
      end
   end

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
   parameter int PA_W = 40
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            done,
   input logic            fault,
   input logic [3:0]      fault_code,
   input logic [31:0]     fault_addr,
   input logic            mem_valid,
   input logic            mem_ready,
   input logic            mem_write,
   input logic [PA_W-1:0] mem_addr,
   input logic [31:0]     mem_wdata,
   input logic            a20_gate
);

   assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

   assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_no_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid || done) |-> !req_ready);

   assert_rsvd_sets_prot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault && fault_code[3] |-> fault_code[0]);

   assert_fault_addr_only_on_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fault_addr) |-> done && fault);

   assert_gate_bit20_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !a20_gate |-> !mem_addr[20]);

endmodule

bind pt_walker pw_checker #(.PA_W(PA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .done       (done),
   .fault      (fault),
   .fault_code (fault_code),
   .fault_addr (fault_addr),
   .mem_valid  (mem_valid),
   .mem_ready  (mem_ready),
   .mem_write  (mem_write),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .a20_gate   (ctl_a20_gate)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
   localparam int PA_W = 40;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [31:0]     req_lin = '0;
   logic [1:0]      req_kind = '0;
   logic            req_user = 1'b0;
   logic            ctl_paging = 1'b0;
   logic            ctl_large = 1'b0;
   logic            ctl_wprot = 1'b0;
   logic            ctl_a20_gate = 1'b1;
   logic [31:0]     ctl_base = '0;
   logic            mem_valid, mem_write;
   logic [PA_W-1:0] mem_addr;
   logic [31:0]     mem_wdata;
   logic            mem_ready;
   logic [31:0]     mem_rdata;
   logic            done, fault;
   logic [PA_W-1:0] phys_addr;
   logic [3:0]      fault_code;
   logic [31:0]     fault_addr;

   always #10 clk = ~clk;

   pt_walker #(.PA_W(PA_W)) u0 (.*);

   // behavioural memory and expectations
   logic [31:0] mem [longint];
   longint      qa[$];
   bit          qw[$];
   logic [31:0] qd[$];
   bit          exp_flt;
   logic [3:0]  exp_code;
   longint      exp_phys;
   logic [31:0] exp_lin, last_flt;
   string       cur_tag = "R1";
   bit          got_done = 0;
   int          nchk = 0, nfail = 0, rdy_cnt = 0;

   function automatic logic [31:0] mget(longint a);
      if (mem.exists(a)) return mem[a];
      return 32'h0;
   endfunction

   function automatic longint msk(longint a);
      return ctl_a20_gate ? a : (a & ~(64'h1 << 20));
   endfunction

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic push(longint a, bit w, logic [31:0] d);
      qa.push_back(a); qw.push_back(w); qd.push_back(d);
   endtask

   task automatic ref_model(logic [31:0] lin, logic [1:0] kind, bit usr);
      longint da, ta;
      logic [31:0] pde, pte, leaf, nl;
      bit wr, uok, rwok;
      qa.delete(); qw.delete(); qd.delete();
      wr = (kind == 2'd1);
      exp_flt = 0; exp_phys = 0; exp_lin = lin;
      exp_code = {1'b0, usr, wr, 1'b0};
      if (!ctl_paging) begin
         exp_phys = msk(longint'(lin));
         return;
      end
      da = msk(longint'((ctl_base & 32'hFFFFF000) + ((lin >> 20) & 32'hFFC)));
      push(da, 0, 0);
      pde = mget(da);
      if (!pde[0]) begin exp_flt = 1; return; end
      if (ctl_large && pde[7]) begin
         if (pde[21]) begin exp_flt = 1; exp_code = {1'b1, usr, wr, 1'b1}; return; end
         leaf = pde; uok = pde[2]; rwok = pde[1]; ta = da;
         exp_phys = msk((longint'(pde[20:13]) << 32) | longint'(pde & 32'hFFC00000)
                        | longint'(lin & 32'h003FFFFF));
      end else begin
         if (!pde[5]) push(da, 1, pde | 32'h20);
         ta = msk(longint'((pde & 32'hFFFFF000) + ((lin >> 10) & 32'hFFC)));
         push(ta, 0, 0);
         pte = mget(ta);
         if (!pte[0]) begin exp_flt = 1; return; end
         leaf = pte; uok = pde[2] && pte[2]; rwok = pde[1] && pte[1];
         exp_phys = msk(longint'((pte & 32'hFFFFF000) | (lin & 32'hFFF)));
      end
      if ((usr && !uok) || (wr && !rwok && (usr || ctl_wprot))) begin
         exp_flt = 1; exp_code = {1'b0, usr, wr, 1'b1}; return;
      end
      nl = leaf | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (nl != leaf) push(ta, 1, nl);
   endtask

   // per-clock comparison of the memory stream and the result
   always @(negedge clk) begin
      rdy_cnt++;
      mem_ready = (rdy_cnt % 3) != 1;
      mem_rdata = mget(longint'(mem_addr));
      if (rst_n && mem_valid && mem_ready) begin
         if (qa.size() == 0) begin
            chk(0, cur_tag, "R4 unexpected access", longint'(mem_addr), 0);
         end else begin
            chk(longint'(mem_addr) == qa[0], cur_tag, "R4 access address", longint'(mem_addr), qa[0]);
            chk(mem_write == qw[0], cur_tag, "R4 access direction", longint'(mem_write), longint'(qw[0]));
            if (qw[0]) chk(mem_wdata == qd[0], cur_tag, "R7 write-back data", longint'(mem_wdata), longint'(qd[0]));
            void'(qa.pop_front()); void'(qw.pop_front()); void'(qd.pop_front());
         end
         if (mem_write) mem[longint'(mem_addr)] = mem_wdata;
      end
      if (rst_n && done) begin
         got_done = 1;
         chk(qa.size() == 0, cur_tag, "R4 missing accesses", qa.size(), 0);
         chk(fault == exp_flt, cur_tag, "fault flag", longint'(fault), longint'(exp_flt));
         if (exp_flt) begin
            last_flt = exp_lin;
            chk(fault_code == exp_code, cur_tag, "R10 fault code", longint'(fault_code), longint'(exp_code));
            chk(fault_addr == exp_lin, cur_tag, "R10 fault address", longint'(fault_addr), longint'(exp_lin));
         end else begin
            chk(longint'(phys_addr) == exp_phys, cur_tag, "physical address", longint'(phys_addr), exp_phys);
            chk(fault_addr == last_flt, cur_tag, "R10 fault address held", longint'(fault_addr), longint'(last_flt));
         end
      end
   end

   task automatic walk(string tag, logic [31:0] lin, logic [1:0] kind, bit usr);
      ref_model(lin, kind, usr);
      cur_tag  = tag;
      got_done = 0;
      req_lin  = lin; req_kind = kind; req_user = usr; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!got_done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL R13 watchdog: done seen %0d expected 1", got_done);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      last_flt = '0;
      mem[64'h10004]    = 32'h00020027;
      mem[64'h2000C]    = 32'h0ABCD067;
      mem[64'h10008]    = 32'h00030007;
      mem[64'h30014]    = 32'h00444007;
      mem[64'h30018]    = 32'h00555003;
      mem[64'h30020]    = 32'h00666025;
      mem[64'h30024]    = 32'h00777021;
      mem[64'h10010]    = 32'h3014A087;
      mem[64'h10014]    = 32'h30200087;
      mem[64'h10018]    = 32'h00120027;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1, "R1", "req_ready in reset", longint'(req_ready), 1);
      chk(done == 1'b0, "R1", "done in reset", longint'(done), 0);
      chk(mem_valid == 1'b0, "R1", "mem_valid in reset", longint'(mem_valid), 0);
      chk(fault_addr == 32'h0, "R1", "fault_addr in reset", longint'(fault_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "req_ready after reset", longint'(req_ready), 1);

      walk("R2", 32'h12345678, 2'd0, 0);                 // paging off passthrough
      ctl_a20_gate = 0;
      walk("R11", 32'h00100ABC, 2'd1, 1);                // gate on passthrough
      ctl_a20_gate = 1;
      ctl_paging = 1; ctl_base = 32'h00010ABC;
      walk("R3", 32'h00403123, 2'd0, 0);                 // 4 KB read
      walk("R7", 32'h00403FF0, 2'd1, 1);                 // A and D already set: no write
      walk("R6", 32'h00805000, 2'd1, 0);                 // dir A clear, leaf A|D
      walk("R7", 32'h00806010, 2'd0, 0);                 // leaf A only
      walk("R5", 32'h00C00000, 2'd1, 1);                 // dir not present
      walk("R5", 32'h00807000, 2'd0, 0);                 // table not present
      walk("R12", 32'h00806010, 2'd0, 1);                // user on supervisor page
      walk("R12", 32'h00808000, 2'd1, 1);                // user write read-only
      walk("R12", 32'h00808004, 2'd1, 0);                // supervisor write, wp off
      ctl_wprot = 1;
      walk("R12", 32'h00809000, 2'd1, 0);                // supervisor write, wp on
      walk("R12", 32'h00808008, 2'd2, 1);                // user fetch as read
      ctl_large = 1;
      walk("R8", 32'h01234567, 2'd0, 1);                 // 4 MB page, high bits
      walk("R9", 32'h01400000, 2'd0, 0);                 // reserved bit 21
      walk("R10", 32'h01400010, 2'd1, 1);                // reserved, write, user
      ctl_large = 0;
      walk("R8", 32'h01234567, 2'd0, 0);                 // large disabled: 4 KB path
      ctl_a20_gate = 0;
      walk("R11", 32'h01803004, 2'd0, 0);                // gated table and result
      ctl_a20_gate = 1; ctl_paging = 0;
      walk("R13", 32'h00000040, 2'd2, 0);
      chk(req_ready == 1'b1, "R13", "idle after done", longint'(req_ready), 1);

      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

endmodule